// File: doc/BRIEF.md
# Asynchronous DRAM Page-Mode Controller

This block sits between a simple host request port and one asynchronous DRAM device with a multiplexed address bus. It turns each host request into a strobe sequence. The row half of the cell address is placed on the shared address pins and latched by a falling row strobe. The column half follows, and a falling column strobe latches it. For reads, the data pins are captured once the column strobe has been low long enough for the data to settle. For writes, the write data and write enable are presented before the column strobe falls.

The controller uses an open-page policy. After an access the row strobe stays low, so a later request to the same row skips row activation. A request to another row first precharges by holding the row strobe high, then opens the new row. A burst read keeps the row strobe low and strobes four columns in turn. The first word arrives in 6 cycles from a closed row and each later word in 3 cycles (6-3-3-3).

The host raises `req_valid` with its fields and holds them until the final `req_ready` pulse of that request. `req_ready` stays low in every wait-state cycle and pulses once for each word returned or written.

Top module: `dpm_ctrl`

## Requirements
- R1: The 24-bit request address splits into row = bits 23:12 and column = bits 11:0. The row is on `dram_addr` in the cycle `dram_ras_n` falls, and the column is on `dram_addr` in every cycle `dram_cas_n` falls.
- R2: A single read to a closed row (the state after reset) pulses `req_ready` and `rsp_valid` in the 6th cycle after the accepting edge. `rsp_data` in that cycle holds the DRAM data at that row and column.
- R3: After an access, `dram_ras_n` stays low while idle. A request to that same open row pulses `req_ready` in the 4th cycle after acceptance.
- R4: A request to a row other than the open one drives `dram_ras_n` high for exactly 2 cycles before it falls again. Its first `req_ready` pulse comes in the 7th cycle.
- R5: A read with `req_burst` = 1 returns four words 3 cycles apart without raising `dram_ras_n`. The columns are taken in the order base, base+1, base+2, base+3, with only the low two column bits counting and wrapping modulo 4.
- R6: `req_ready` is low in every cycle that returns no word and is high for exactly one cycle per word. `rsp_valid` is high in exactly the `req_ready` cycles of read requests and is low for writes.
- R7: `dram_cas_n` is low for exactly 2 cycles per column access and only while `dram_ras_n` is low. It goes high again before the next column is strobed.
- R8: For a write, `dram_we_n` is low and `dram_dq_oe` is high from the cycle before `dram_cas_n` falls. The DRAM stores `req_wdata` at the addressed cell, and `req_ready` pulses in the same cycle it would for a read of that row state (4, 6 or 7).
- R9: `req_burst` is ignored for writes: a write with `req_burst` = 1 produces one column strobe and one `req_ready` pulse.
- R10: During reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, and `dram_dq_oe`, `req_ready` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present; held until the final ready pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-word page burst (reads only) |
| req_addr | input | 24 | Cell address, row in the upper half |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-cycle pulse per completed word |
| rsp_valid | output | 1 | Read data valid on `rsp_data` |
| rsp_data | output | 16 | Read data |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 16 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
The assertions assume the host keeps `req_valid` and the request fields stable from the accepting edge until the final `req_ready` pulse. They also assume that `dram_dq_in` is valid by the end of the second low cycle of `dram_cas_n`. The bench driver issues one request at a time, drops `req_valid` in the cycle it sees the last pulse, and waits one idle cycle before the next request. Its DRAM model puts data on `dram_dq_in` from the first cycle the column strobe is seen low, so the capture point always meets the settling assumption.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    // Sequencer phases; encoding 0 must be the idle phase (reset value).
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting; row strobe low only if a page is open
        ST_PRE  = 3'd1,   // row strobe high: precharge / row address setup
        ST_RAS  = 3'd2,   // row strobe falls, row address held
        ST_CSET = 3'd3,   // column address setup, column strobe high
        ST_CAS  = 3'd4    // column strobe low, data settling / write pulse
    } dpm_state_e;

    // Strobe bundle decoded from the sequencer phase.
    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic dq_oe;
        logic sel_col;
    } dpm_strobe_t;

endpackage

// File: rtl/dpm_row_track.sv
// Remembers which row is open in the device and compares a candidate row.
module dpm_row_track #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_set,
    input  logic             open_clr,
    input  logic [ROW_W-1:0] set_row,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             row_open,
    output logic             row_hit
);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
    } track_t;

    track_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (open_clr) begin
            trk_d.open = 1'b0;
        end
        if (open_set) begin
            trk_d.open = 1'b1;
            trk_d.row  = set_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign row_open = trk_q.open;
    assign row_hit  = (trk_q.row == cmp_row);

endmodule

// File: rtl/dpm_addr_mux.sv
// Drives the shared address pins: row half or burst-adjusted column half.
module dpm_addr_mux #(
    parameter int ROW_W     = 12,
    parameter int COL_W     = 12,
    parameter int BURST_LEN = 4
) (
    input  logic [ROW_W-1:0]                                     row,
    input  logic [COL_W-1:0]                                     col_base,
    input  logic [((BURST_LEN > 1) ? $clog2(BURST_LEN) : 1)-1:0] beat,
    input  logic                                                 sel_col,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0]         addr
);

    localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int IDX_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

    logic [MUX_W-1:0] row_ext;
    logic [MUX_W-1:0] col_ext;
    logic [COL_W-1:0] col_eff;
    logic [IDX_W-1:0] col_low;

    // Only the low column bits advance, so a burst wraps inside its group
    // and never leaves the open row.
    assign col_low = col_base[IDX_W-1:0] + beat;
    assign col_eff = {col_base[COL_W-1:IDX_W], col_low};

    generate
        if (ROW_W == MUX_W) begin : g_row_full
            assign row_ext = row;
        end else begin : g_row_pad
            assign row_ext = {{(MUX_W-ROW_W){1'b0}}, row};
        end
        if (COL_W == MUX_W) begin : g_col_full
            assign col_ext = col_eff;
        end else begin : g_col_pad
            assign col_ext = {{(MUX_W-COL_W){1'b0}}, col_eff};
        end
    endgenerate

    assign addr = sel_col ? col_ext : row_ext;

endmodule

// File: rtl/dpm_seq.sv
// Phase sequencer: accepts host requests, steps the strobe phases, counts
// precharge and column-strobe cycles, captures read data.
module dpm_seq #(
    parameter int ROW_W      = 12,
    parameter int COL_W      = 12,
    parameter int DATA_W     = 16,
    parameter int BURST_LEN  = 4,
    parameter int PRE_CYCLES = 2,
    parameter int CAS_CYCLES = 2
) (
    input  logic                                                 clk,
    input  logic                                                 rst_n,
    input  logic                                                 req_valid,
    input  logic                                                 req_write,
    input  logic                                                 req_burst,
    input  logic [ROW_W-1:0]                                     req_row,
    input  logic [COL_W-1:0]                                     req_col,
    input  logic [DATA_W-1:0]                                    req_wdata,
    input  logic                                                 row_open,
    input  logic                                                 row_hit,
    output logic                                                 open_set,
    output logic                                                 open_clr,
    output dpm_pkg::dpm_strobe_t                                 strb,
    output logic [ROW_W-1:0]                                     cur_row,
    output logic [COL_W-1:0]                                     cur_col,
    output logic [((BURST_LEN > 1) ? $clog2(BURST_LEN) : 1)-1:0] cur_beat,
    output logic [DATA_W-1:0]                                    wdata,
    input  logic [DATA_W-1:0]                                    dq_in,
    output logic                                                 ready,
    output logic                                                 rvalid,
    output logic [DATA_W-1:0]                                    rdata
);

    import dpm_pkg::*;

    localparam int IDX_W   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam int CNT_MAX = (PRE_CYCLES > CAS_CYCLES) ? PRE_CYCLES : CAS_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(BURST_LEN - 1);

    typedef struct packed {
        dpm_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [IDX_W-1:0]   beat;
        logic [ROW_W-1:0]   row;
        logic [COL_W-1:0]   col;
        logic               wr;
        logic               burst;
        logic [DATA_W-1:0]  wdata;
        logic               ready;
        logic               rvalid;
        logic [DATA_W-1:0]  rdata;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d        = seq_q;
        seq_d.ready  = 1'b0;
        seq_d.rvalid = 1'b0;
        open_set     = 1'b0;
        open_clr     = 1'b0;

        unique case (seq_q.st)
            ST_IDLE: begin
                // The final ready pulse is still on the port while idle;
                // the host's request is taken only after that cycle.
                if (req_valid && !seq_q.ready) begin
                    seq_d.row   = req_row;
                    seq_d.col   = req_col;
                    seq_d.wr    = req_write;
                    seq_d.burst = req_burst && !req_write;
                    seq_d.wdata = req_wdata;
                    seq_d.beat  = '0;
                    if (row_open && row_hit) begin
                        seq_d.st = ST_CSET;
                    end else begin
                        seq_d.st = ST_PRE;
                        open_clr = 1'b1;
                        // From an open page the full precharge is paid;
                        // from a closed page one setup cycle suffices.
                        seq_d.cnt = row_open ? CNT_W'(PRE_CYCLES - 1) : '0;
                    end
                end
            end
            ST_PRE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st = ST_RAS;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_RAS: begin
                seq_d.st = ST_CSET;
                open_set = 1'b1;
            end
            ST_CSET: begin
                seq_d.st  = ST_CAS;
                seq_d.cnt = CNT_W'(CAS_CYCLES - 1);
            end
            ST_CAS: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else begin
                    seq_d.ready = 1'b1;
                    if (!seq_q.wr) begin
                        seq_d.rvalid = 1'b1;
                        seq_d.rdata  = dq_in;
                    end
                    if (seq_q.burst && (seq_q.beat != LAST_BEAT)) begin
                        seq_d.beat = seq_q.beat + 1'b1;
                        seq_d.st   = ST_CSET;
                    end else begin
                        seq_d.st = ST_IDLE;
                    end
                end
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // Strobe decode from the registered phase.
    logic in_col;
    assign in_col = (seq_q.st == ST_CSET) || (seq_q.st == ST_CAS);

    always_comb begin
        strb.ras_n   = !((seq_q.st == ST_RAS) || in_col ||
                         ((seq_q.st == ST_IDLE) && row_open));
        strb.cas_n   = (seq_q.st != ST_CAS);
        strb.we_n    = !(seq_q.wr && in_col);
        strb.dq_oe   = seq_q.wr && in_col;
        strb.sel_col = in_col;
    end

    assign cur_row  = seq_q.row;
    assign cur_col  = seq_q.col;
    assign cur_beat = seq_q.beat;
    assign wdata    = seq_q.wdata;
    assign ready    = seq_q.ready;
    assign rvalid   = seq_q.rvalid;
    assign rdata    = seq_q.rdata;

endmodule

// File: rtl/dpm_ctrl.sv
module dpm_ctrl #(
    parameter int ROW_W      = 12,
    parameter int COL_W      = 12,
    parameter int DATA_W     = 16,
    parameter int BURST_LEN  = 4,
    parameter int PRE_CYCLES = 2,
    parameter int CAS_CYCLES = 2
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         req_valid,
    input  logic                                         req_write,
    input  logic                                         req_burst,
    input  logic [ROW_W+COL_W-1:0]                       req_addr,
    input  logic [DATA_W-1:0]                            req_wdata,
    output logic                                         req_ready,
    output logic                                         rsp_valid,
    output logic [DATA_W-1:0]                            rsp_data,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic                                         dram_ras_n,
    output logic                                         dram_cas_n,
    output logic                                         dram_we_n,
    output logic [DATA_W-1:0]                            dram_dq_out,
    output logic                                         dram_dq_oe,
    input  logic [DATA_W-1:0]                            dram_dq_in
);

    localparam int ADDR_W = ROW_W + COL_W;
    localparam int IDX_W  = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

    logic [ROW_W-1:0]     in_row;
    logic [COL_W-1:0]     in_col;
    logic                 row_open;
    logic                 row_hit;
    logic                 open_set;
    logic                 open_clr;
    dpm_pkg::dpm_strobe_t strb;
    logic [ROW_W-1:0]     cur_row;
    logic [COL_W-1:0]     cur_col;
    logic [IDX_W-1:0]     cur_beat;

    assign in_row = req_addr[ADDR_W-1:COL_W];
    assign in_col = req_addr[COL_W-1:0];

    dpm_row_track #(
        .ROW_W (ROW_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_set (open_set),
        .open_clr (open_clr),
        .set_row  (cur_row),
        .cmp_row  (in_row),
        .row_open (row_open),
        .row_hit  (row_hit)
    );

    dpm_seq #(
        .ROW_W      (ROW_W),
        .COL_W      (COL_W),
        .DATA_W     (DATA_W),
        .BURST_LEN  (BURST_LEN),
        .PRE_CYCLES (PRE_CYCLES),
        .CAS_CYCLES (CAS_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_burst (req_burst),
        .req_row   (in_row),
        .req_col   (in_col),
        .req_wdata (req_wdata),
        .row_open  (row_open),
        .row_hit   (row_hit),
        .open_set  (open_set),
        .open_clr  (open_clr),
        .strb      (strb),
        .cur_row   (cur_row),
        .cur_col   (cur_col),
        .cur_beat  (cur_beat),
        .wdata     (dram_dq_out),
        .dq_in     (dram_dq_in),
        .ready     (req_ready),
        .rvalid    (rsp_valid),
        .rdata     (rsp_data)
    );

    dpm_addr_mux #(
        .ROW_W     (ROW_W),
        .COL_W     (COL_W),
        .BURST_LEN (BURST_LEN)
    ) u_amux (
        .row      (cur_row),
        .col_base (cur_col),
        .beat     (cur_beat),
        .sel_col  (strb.sel_col),
        .addr     (dram_addr)
    );

    assign dram_ras_n = strb.ras_n;
    assign dram_cas_n = strb.cas_n;
    assign dram_we_n  = strb.we_n;
    assign dram_dq_oe = strb.dq_oe;

endmodule

// File: rtl/dpm_ctrl_chk.sv
// Protocol checker attached to the controller's pins.
module dpm_ctrl_chk #(
    parameter int PRE_CYCLES = 2,
    parameter int CAS_CYCLES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic dq_oe,
    input logic ready,
    input logic rvalid
);

    localparam int CR_W = $clog2(CAS_CYCLES + 2);
    localparam int RR_W = $clog2(PRE_CYCLES + 2);

    logic [CR_W-1:0] cas_run;
    logic [RR_W-1:0] ras_run;
    logic            seen_open;

    // Saturating run-length counters of the strobe levels.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cas_run   <= '0;
            ras_run   <= '0;
            seen_open <= 1'b0;
        end else begin
            if (cas_n) begin
                cas_run <= '0;
            end else if (cas_run != CR_W'(CAS_CYCLES + 1)) begin
                cas_run <= cas_run + 1'b1;
            end
            if (!ras_n) begin
                ras_run <= '0;
            end else if (ras_run != RR_W'(PRE_CYCLES + 1)) begin
                ras_run <= ras_run + 1'b1;
            end
            if (!ras_n) begin
                seen_open <= 1'b1;
            end
        end
    end

    assert_cas_in_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    assert_cas_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> (cas_run == CR_W'(CAS_CYCLES)));

    assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && seen_open) |-> (ras_run >= RR_W'(PRE_CYCLES)));

    assert_we_setup_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !we_n) |-> ($past(!we_n) && $past(dq_oe)));

    assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    assert_rvalid_in_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> ready);

    assert_ready_after_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> cas_n);

endmodule

bind dpm_ctrl dpm_ctrl_chk #(
    .PRE_CYCLES (PRE_CYCLES),
    .CAS_CYCLES (CAS_CYCLES)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ras_n  (dram_ras_n),
    .cas_n  (dram_cas_n),
    .we_n   (dram_we_n),
    .dq_oe  (dram_dq_oe),
    .ready  (req_ready),
    .rvalid (rsp_valid)
);

// File: tb/dpm_ctrl_bench.sv
module dpm_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ROW_W  = 12;
    localparam int COL_W  = 12;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic              req_burst = 1'b0;
    logic [23:0]       req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ready;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic [11:0]       dram_addr;
    logic              dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
    logic [DATA_W-1:0] dram_dq_out;
    logic [DATA_W-1:0] dram_dq_in = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpm_ctrl u_dpm_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_burst(req_burst), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    bit     finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_eq(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pattern(logic [23:0] a);
        return a[15:0] ^ {a[23:16], 8'hA5};
    endfunction

    // DRAM model storage and bench shadow of expected contents.
    logic [15:0] dmem [logic [23:0]];
    logic [15:0] shadow [logic [23:0]];

    function automatic logic [15:0] dmem_rd(logic [23:0] a);
        return dmem.exists(a) ? dmem[a] : pattern(a);
    endfunction
    function automatic logic [15:0] shadow_rd(logic [23:0] a);
        return shadow.exists(a) ? shadow[a] : pattern(a);
    endfunction

    typedef struct {
        longint      t;
        bit          rd;
        logic [15:0] d;
    } item_t;

    item_t       sb[$];
    logic [11:0] col_q[$];
    logic [11:0] exp_row = '0;
    bit          b_open = 0;
    logic [11:0] b_row = '0;

    logic [11:0] m_row = '0, m_col = '0;
    logic        ras_p = 1'b1, cas_p = 1'b1, we_p = 1'b1;
    int          cas_falls = 0, ras_rises = 0;
    int          ras_high_run = 0, last_pre_run = 0, cas_low_run = 0;

    // DRAM model and scoreboard monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ras_p && !dram_ras_n) begin
                check_eq("R1", "row on pins at row strobe", dram_addr, exp_row);
                last_pre_run = ras_high_run;
                m_row = dram_addr;
            end
            if (!ras_p && dram_ras_n) ras_rises++;
            ras_high_run = dram_ras_n ? ras_high_run + 1 : 0;

            if (cas_p && !dram_cas_n) begin
                cas_falls++;
                m_col = dram_addr;
                if (col_q.size() == 0) begin
                    check_eq("R1", "unexpected column strobe", 1, 0);
                end else begin
                    check_eq("R5", "column order", dram_addr, col_q.pop_front());
                end
                if (!dram_we_n) begin
                    check_eq("R8", "we_n low before column strobe", we_p, 0);
                    check_eq("R8", "data driven at column strobe", dram_dq_oe, 1);
                    dmem[{m_row, m_col}] = dram_dq_out;
                end
                dram_dq_in = dmem_rd({m_row, m_col});
            end
            if (!cas_p && dram_cas_n) begin
                check_eq("R7", "column strobe low cycles", cas_low_run, 2);
                dram_dq_in = '0;
            end
            cas_low_run = dram_cas_n ? 0 : cas_low_run + 1;
            ras_p = dram_ras_n;
            cas_p = dram_cas_n;
            we_p  = dram_we_n;

            if (req_ready) begin
                if (sb.size() == 0) begin
                    check_eq("R6", "ready with no word due", 1, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check_eq("R6", "ready cycle", cyc, it.t);
                    check_eq("R6", "rsp_valid with ready", rsp_valid, it.rd);
                    if (it.rd) check_eq("R2", "read data", rsp_data, it.d);
                end
            end else if (rsp_valid) begin
                check_eq("R6", "rsp_valid without ready", 1, 0);
            end
        end
    end

    // Driver: predicts timing from its own page state, pushes expectations.
    task automatic issue(bit wr, bit bu, logic [23:0] a, logic [15:0] wd);
        int lat;
        int words;
        logic [11:0] row;
        row = a[23:12];
        if (b_open && b_row == row) lat = 4;
        else if (b_open)            lat = 7;
        else                        lat = 6;
        b_open  = 1;
        b_row   = row;
        exp_row = row;
        words = (bu && !wr) ? 4 : 1;
        for (int k = 0; k < words; k++) begin
            item_t it;
            logic [11:0] col;
            col = {a[11:2], a[1:0] + 2'(k)};
            col_q.push_back(col);
            it.t  = cyc + lat + 3 * k;
            it.rd = !wr;
            it.d  = wr ? 16'h0 : shadow_rd({row, col});
            sb.push_back(it);
        end
        if (wr) shadow[a] = wd;
        req_write = wr;
        req_burst = bu;
        req_addr  = a;
        req_wdata = wd;
        req_valid = 1'b1;
        wait (sb.size() == 0);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        int r0, c0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check_eq("R10", "ras_n in reset", dram_ras_n, 1);
        check_eq("R10", "cas_n in reset", dram_cas_n, 1);
        check_eq("R10", "we_n in reset", dram_we_n, 1);
        check_eq("R10", "dq_oe in reset", dram_dq_oe, 0);
        check_eq("R10", "ready in reset", req_ready, 0);
        check_eq("R10", "rsp_valid in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: closed-row single read, 6 cycles
        issue(0, 0, 24'h123456, 16'h0);
        // R3: page stays open while idle, same-row hit in 4 cycles
        check_eq("R3", "row strobe held low when idle", dram_ras_n, 0);
        issue(0, 0, 24'h123457, 16'h0);

        // R4/R8: write to another row, precharge 2 cycles, ready at 7
        issue(1, 0, 24'h200010, 16'hBEEF);
        check_eq("R4", "precharge cycles", last_pre_run, 2);
        check_eq("R8", "data stored in DRAM", dmem_rd(24'h200010), 16'hBEEF);
        issue(0, 0, 24'h200010, 16'h0);

        // R5: burst on open row, wrap order 2,3,0,1, no row strobe release
        r0 = ras_rises; c0 = cas_falls;
        issue(0, 1, 24'h200012, 16'h0);
        check_eq("R5", "row strobe rises in burst", ras_rises - r0, 0);
        check_eq("R5", "column strobes in burst", cas_falls - c0, 4);

        // R5/R4: burst to a new row at the top of the column space
        issue(0, 1, 24'h3FFFFE, 16'h0);
        check_eq("R4", "precharge cycles before burst", last_pre_run, 2);

        // R9: burst flag ignored on a write
        c0 = cas_falls;
        issue(1, 1, 24'h3FF001, 16'h1234);
        check_eq("R9", "column strobes for burst-flagged write", cas_falls - c0, 1);
        issue(0, 0, 24'h3FF001, 16'h0);
        issue(0, 0, 24'h3FF002, 16'h0);

        // back to the first row: miss again
        issue(0, 1, 24'h123454, 16'h0);

        repeat (5) @(negedge clk);
        check_eq("R6", "no outstanding words", sb.size(), 0);
        check_eq("R6", "ready idle at end", req_ready, 0);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R6 watchdog expired: actual hung expected done");
            summary();
            $finish;
        end
    end

endmodule